// File: doc/BRIEF.md
# Wired-OR Multi-Barrier Register File

This block gives a large group of thread units a set of hardware barriers that cost no shared-memory traffic. Each thread owns a small private register of barrier flags and updates it through its own write port, with a bit mask. The block ORs the same bit position across every thread's register and returns the result on one shared read vector. Each thread therefore polls a local copy of the combined state without competing with any other thread.

The flag register holds several independent barriers, two bits each. At any time one bit of a pair is the current phase and the other is the next phase. A thread taking part in a barrier first sets its current bit. It enters the barrier with one masked write that clears the current bit and sets the next bit. When the ORed current bit drops to zero, every participant has arrived. The roles of the two bits then swap for the following episode. Threads that do not take part leave both bits of the pair at zero and have no effect on it.

The block tracks the phase of each barrier. It raises a one-cycle completion pulse when the ORed current bit falls, and it exposes which bit of each pair is current.

Top module: `barrier_orfile`

## Requirements
- R1: While reset is high, and on the first cycle after it, every thread register, `rd_or`, `bar_done` and `cur_sel` read as zero. With `cur_sel` at zero, the even bit of each pair is current.
- R2: Bit i of `rd_or` is the OR of bit i over all thread registers. A write accepted on clock edge k is not visible after edge k and is visible after edge k+1.
- R3: A write changes only the register bits whose mask bit is 1. Bits whose mask bit is 0 keep their value.
- R4: When a thread's `wr_en` bit is low, its data and mask lanes have no effect on its register.
- R5: Barrier b uses bits 2b and 2b+1. Activity on one barrier leaves the other barriers' `rd_or` bits, `bar_done` bits and `cur_sel` bits unchanged.
- R6: `bar_done[b]` is high for exactly one cycle. That cycle is the one on which the registered OR of barrier b's current bit changes from 1 to 0.
- R7: On the cycle `bar_done[b]` is high, `cur_sel[b]` toggles. Bit 2b+`cur_sel[b]` is current. `cur_sel[b]` changes at no other time.
- R8: While any participant still holds its current bit at 1, the barrier does not complete. Threads whose pair bits are both 0 do not hold it open.
- R9: A 1-to-0 change of a barrier's next-phase bit produces no completion pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | N_THREADS | Per-thread write strobe |
| wr_data | input | N_THREADS*2*N_BARRIERS | Per-thread write data, thread t in lane t |
| wr_mask | input | N_THREADS*2*N_BARRIERS | Per-thread bit mask, 1 = update that bit |
| rd_or | output | 2*N_BARRIERS | Registered OR of all thread registers |
| bar_done | output | N_BARRIERS | Completion pulse per barrier |
| cur_sel | output | N_BARRIERS | Which bit of each pair is current (0 = even bit) |

## Verification
The assertions assume that reset is held for at least one edge before any checked cycle. They also assume that the thread registers change only through write strobes, so two quiet strobe cycles freeze `rd_or`. The bench keeps within these assumptions: it drives all write lanes at the falling edge, raises strobes only for the single staging cycle of each write, and releases reset only after several edges. The bench drives stray data on disabled lanes, and it walks barriers through complete two-phase cycles, including a flip back to the even bit.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    // bit index of the current-phase bit of barrier b
    function automatic int cur_bit(input int b, input phase_e ph);
        return 2 * b + ((ph == PH_ODD) ? 1 : 0);
    endfunction

    // masked merge of new data into an old register value
    function automatic logic [7:0] merge8(input logic [7:0] old_v,
                                          input logic [7:0] new_v,
                                          input logic [7:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

endpackage

// File: rtl/bar_thread_reg.sv
module bar_thread_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] data,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= (q & ~mask) | (data & mask);
    end
endmodule

// File: rtl/bar_or_reduce.sv
module bar_or_reduce #(
    parameter int N = 128,
    parameter int W = 8
) (
    input  logic [N*W-1:0] regs_flat,
    output logic [W-1:0]   or_out
);
    always_comb begin
        or_out = '0;
        for (int t = 0; t < N; t++)
            or_out = or_out | regs_flat[t*W +: W];
    end
endmodule

// File: rtl/bar_phase_track.sv
module bar_phase_track
    import barrier_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pair_q,    // registered OR of this pair
    input  logic [1:0] pair_nx,   // OR value loaded at this edge
    output logic       done,
    output logic       phase
);
    phase_e ph_q;
    logic   fall;

    always_comb begin
        if (ph_q == PH_ODD)
            fall = pair_q[1] & ~pair_nx[1];
        else
            fall = pair_q[0] & ~pair_nx[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_EVEN;
            done <= 1'b0;
        end else begin
            done <= fall;
            if (fall)
                ph_q <= (ph_q == PH_EVEN) ? PH_ODD : PH_EVEN;
        end
    end

    assign phase = (ph_q == PH_ODD);
endmodule

// File: rtl/barrier_orfile.sv
module barrier_orfile #(
    parameter int N_THREADS  = 128,
    parameter int N_BARRIERS = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [N_THREADS-1:0]               wr_en,
    input  logic [N_THREADS*2*N_BARRIERS-1:0]  wr_data,
    input  logic [N_THREADS*2*N_BARRIERS-1:0]  wr_mask,
    output logic [2*N_BARRIERS-1:0]            rd_or,
    output logic [N_BARRIERS-1:0]              bar_done,
    output logic [N_BARRIERS-1:0]              cur_sel
);
    localparam int W = 2 * N_BARRIERS;

    logic [N_THREADS*W-1:0] regs_flat;
    logic [W-1:0]           or_nx;

    generate
        for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
            bar_thread_reg #(.W(W)) u_reg (
                .clk (clk),
                .rst (rst),
                .we  (wr_en[t]),
                .data(wr_data[t*W +: W]),
                .mask(wr_mask[t*W +: W]),
                .q   (regs_flat[t*W +: W])
            );
        end
    endgenerate

    bar_or_reduce #(.N(N_THREADS), .W(W)) u_or (
        .regs_flat(regs_flat),
        .or_out   (or_nx)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_or <= '0;
        else
            rd_or <= or_nx;
    end

    generate
        for (genvar b = 0; b < N_BARRIERS; b++) begin : g_bar
            bar_phase_track u_ph (
                .clk    (clk),
                .rst    (rst),
                .pair_q (rd_or[2*b +: 2]),
                .pair_nx(or_nx[2*b +: 2]),
                .done   (bar_done[b]),
                .phase  (cur_sel[b])
            );
        end
    endgenerate
endmodule

// File: rtl/bar_checker.sv
module bar_checker #(
    parameter int N_THREADS  = 128,
    parameter int N_BARRIERS = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic [N_THREADS-1:0]      wr_en,
    input logic [2*N_BARRIERS-1:0]   rd_or,
    input logic [N_BARRIERS-1:0]     bar_done,
    input logic [N_BARRIERS-1:0]     cur_sel
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rd_or == '0 && bar_done == '0 && cur_sel == '0));

    // R2
    quiet_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|$past(wr_en)) && !(|$past(wr_en, 2))) |-> $stable(rd_or));

    generate
        for (genvar b = 0; b < N_BARRIERS; b++) begin : g_b
            // R6
            done_fall_chk: assert property (@(posedge clk) disable iff (rst)
                bar_done[b] |->
                    (($past(cur_sel[b]) ? $past(rd_or[2*b+1]) : $past(rd_or[2*b])) &&
                     !($past(cur_sel[b]) ? rd_or[2*b+1] : rd_or[2*b])));

            // R7
            flip_on_done_chk: assert property (@(posedge clk) disable iff (rst)
                bar_done[b] |-> (cur_sel[b] != $past(cur_sel[b])));

            // R7
            hold_phase_chk: assert property (@(posedge clk) disable iff (rst)
                !bar_done[b] |-> $stable(cur_sel[b]));
        end
    endgenerate
endmodule

bind barrier_orfile bar_checker #(
    .N_THREADS (N_THREADS),
    .N_BARRIERS(N_BARRIERS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_or   (rd_or),
    .bar_done(bar_done),
    .cur_sel (cur_sel)
);

// File: tb/test_barrier_orfile.sv
module test_barrier_orfile;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 128;
    localparam int NB = 4;
    localparam int W  = 2 * NB;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NT-1:0]     wr_en = '0;
    logic [NT*W-1:0]   wr_data = '0;
    logic [NT*W-1:0]   wr_mask = '0;
    logic [W-1:0]      rd_or;
    logic [NB-1:0]     bar_done;
    logic [NB-1:0]     cur_sel;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    barrier_orfile #(.N_THREADS(NT), .N_BARRIERS(NB)) i_barrier_orfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_mask(wr_mask), .rd_or(rd_or), .bar_done(bar_done), .cur_sel(cur_sel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [W-1:0] e_or,
                             input logic [NB-1:0] e_done, input logic [NB-1:0] e_sel);
        chk(rd_or == e_or, {tag, " rd_or"}, int'(rd_or), int'(e_or));
        chk(bar_done == e_done, {tag, " bar_done"}, int'(bar_done), int'(e_done));
        chk(cur_sel == e_sel, {tag, " cur_sel"}, int'(cur_sel), int'(e_sel));
    endtask

    // stage one thread's write for the next edge (called at negedge)
    task automatic stage(input int t, input logic [W-1:0] d, input logic [W-1:0] m);
        wr_en[t] = 1'b1;
        wr_data[t*W +: W] = d;
        wr_mask[t*W +: W] = m;
    endtask

    // let the staged writes be taken at one edge, then clear strobes
    task automatic commit();
        @(negedge clk);
        wr_en   = '0;
        wr_data = '0;
        wr_mask = '0;
    endtask

    task automatic test_reset();
        check_all("R1 reset", 8'h00, 4'h0, 4'h0);
    endtask

    task automatic test_or_latency();
        stage(5, 8'h82, 8'hFF);
        commit();
        check_all("R2 not yet visible", 8'h00, 4'h0, 4'h0);
        @(negedge clk);
        check_all("R2 one thread", 8'h82, 4'h0, 4'h0);
        stage(127, 8'h20, 8'hFF);
        commit();
        @(negedge clk);
        check_all("R2 two threads", 8'hA2, 4'h0, 4'h0);
    endtask

    task automatic test_mask();
        // clear bit1 of thread 5 only, bit7 must survive; bit1 is a next bit (R9)
        stage(5, 8'h00, 8'h02);
        commit();
        @(negedge clk);
        check_all("R3 R9 masked clear", 8'hA0, 4'h0, 4'h0);
    endtask

    task automatic test_disabled();
        wr_data[5*W +: W] = 8'h00;
        wr_mask[5*W +: W] = 8'hFF;
        wr_data[127*W +: W] = 8'hFF;
        wr_mask[127*W +: W] = 8'hFF;
        commit();
        @(negedge clk);
        check_all("R4 disabled lanes", 8'hA0, 4'h0, 4'h0);
        stage(5, 8'h00, 8'hFF);
        stage(127, 8'h00, 8'hFF);
        commit();
        @(negedge clk);
        check_all("R9 next bits fall", 8'h00, 4'h0, 4'h0);
    endtask

    task automatic test_episode_even();
        stage(0, 8'h04, 8'h0C);
        stage(5, 8'h04, 8'h0C);
        stage(127, 8'h04, 8'h0C);
        commit();
        @(negedge clk);
        check_all("R8 armed", 8'h04, 4'h0, 4'h0);
        stage(0, 8'h08, 8'h0C);
        commit();
        @(negedge clk);
        check_all("R8 one arrived", 8'h0C, 4'h0, 4'h0);
        stage(5, 8'h08, 8'h0C);
        commit();
        @(negedge clk);
        check_all("R8 two arrived", 8'h0C, 4'h0, 4'h0);
        stage(127, 8'h08, 8'h0C);
        commit();
        check_all("R6 not early", 8'h0C, 4'h0, 4'h0);
        @(negedge clk);
        check_all("R6 R7 R5 complete", 8'h08, 4'h2, 4'h2);
        @(negedge clk);
        check_all("R6 single pulse", 8'h08, 4'h0, 4'h2);
    endtask

    task automatic test_episode_odd();
        stage(0, 8'h04, 8'h0C);
        stage(5, 8'h04, 8'h0C);
        commit();
        @(negedge clk);
        check_all("R7 R8 odd phase pending", 8'h0C, 4'h0, 4'h2);
        stage(127, 8'h04, 8'h0C);
        commit();
        @(negedge clk);
        check_all("R7 odd phase complete", 8'h04, 4'h2, 4'h0);
        @(negedge clk);
        check_all("R6 odd single pulse", 8'h04, 4'h0, 4'h0);
    endtask

    task automatic test_independent();
        stage(127, 8'h40, 8'hC0);
        commit();
        @(negedge clk);
        check_all("R5 arm barrier3", 8'h44, 4'h0, 4'h0);
        stage(127, 8'h80, 8'hC0);
        commit();
        @(negedge clk);
        check_all("R5 barrier3 only", 8'h84, 4'h8, 4'h8);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_all("R1 during reset", 8'h00, 4'h0, 4'h0);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_or_latency();
        test_mask();
        test_disabled();
        test_episode_even();
        test_episode_odd();
        test_independent();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule